// File: doc/BRIEF.md
# Configurable Parallel-to-Serial Transmit Serializer

This block takes a parallel word from an upstream line-encoding stage and emits it as a serial stream, one bit per serial clock, straight into the transmit output buffer. A two-bit select picks one of four word lengths: 8, 10, 16 or 20 bits. The serial stream comes from the low-order bits of a 20-bit input bus.

Two per-word controls shape the stream. The first inverts every transmitted bit, which undoes a swapped differential pair on the board. The second switches the order from least-significant-first to most-significant-first within the active width. The block samples all controls and the length select only when it accepts a word, so a word can never be cut short, stretched or half-inverted.

A ready pulse during the final bit of a word lets the next word follow with no idle gap. If no word arrives in time, the line drops to low and an underflow flag is raised until the next load.

Top module: `par2ser_tx`

## Requirements
- R1: `width_sel_i` selects the word length: code 0 gives 8 bits, 1 gives 10, 2 gives 16 and 3 gives 20. Exactly that many bits are emitted per accepted word, one per clock. Bit 0 of a word appears on `ser_o` in the cycle right after the edge at which the word is accepted.
- R2: With `msb_first_i` low, bit 0 of the word is sent first and bit N-1 last, where N is the selected length.
- R3: With `msb_first_i` high, bit N-1 is sent first and bit 0 last.
- R4: With `invert_i` high, every one of the N transmitted bits is the logical complement of the corresponding word bit.
- R5: `width_sel_i`, `invert_i`, `msb_first_i` and `word_i` are sampled only at the edge where `load_i && ready_o`. Changing them during a word has no effect on that word.
- R6: Bits of `word_i` at positions N and above are ignored.
- R7: While a word is in flight, `ready_o` is high only in the cycle in which its last bit is on `ser_o`. A load in that cycle puts the next word's first bit out on the very next cycle, with no gap.
- R8: After the synchronous reset `rst`, `ser_o` and `underflow_o` are low and `ready_o` is high. No bit is emitted until the first word is accepted.
- R9: If no load occurs during a word's last bit, then from the next cycle `ser_o` is low and `underflow_o` and `ready_o` are high. This lasts until a word is accepted, and that load clears `underflow_o` at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 20 | Parallel word; only the low N bits are used |
| width_sel_i | input | 2 | Word length code (0:8, 1:10, 2:16, 3:20) |
| invert_i | input | 1 | Invert every bit of the word being loaded |
| msb_first_i | input | 1 | Send the most significant active bit first |
| load_i | input | 1 | Offer a word; accepted when `ready_o` is high |
| ready_o | output | 1 | Block can accept a word at the next edge |
| ser_o | output | 1 | Serial data output, one bit per clock |
| underflow_o | output | 1 | No word was supplied when the last one ended |

## Verification
On every cycle, the bound checker tracks each accepted word's length and confirms three things. First, `ready_o` rises exactly in the last-bit cycle. Second, a missed load turns into underflow with a low line. Third, the line and the flag stay quiet from reset until the first load. What those checks cannot show is which bits travel in which order. Bit order, inversion, masking of the upper bus bits and immunity to mid-word control changes are therefore shown only by the bench's scenarios. These scenarios compare each captured serial word against a value rebuilt from the requirements.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  localparam int unsigned PTX_NUM_FACT = 4;

  typedef enum logic [1:0] {
    PTX_LEN_A = 2'd0,
    PTX_LEN_B = 2'd1,
    PTX_LEN_C = 2'd2,
    PTX_LEN_D = 2'd3
  } ptx_len_e;
endpackage

// File: rtl/ptx_word_prep.sv
// Builds the word image to shift out: masked to the active width,
// optionally reordered MSB-first, optionally inverted.
module ptx_word_prep
  import ptx_pkg::*;
#(
  parameter int unsigned FACT0 = 8,
  parameter int unsigned FACT1 = 10,
  parameter int unsigned FACT2 = 16,
  parameter int unsigned FACT3 = 20,
  localparam int unsigned MAX_W = FACT3,
  localparam int unsigned CNT_W = $clog2(MAX_W)
) (
  input  logic [MAX_W-1:0] word_i,
  input  ptx_len_e         sel_i,
  input  logic             invert_i,
  input  logic             msb_first_i,
  output logic [MAX_W-1:0] image_o,
  output logic [CNT_W-1:0] last_idx_o
);

  function automatic int unsigned fact_of(input int unsigned k);
    case (k)
      0:       return FACT0;
      1:       return FACT1;
      2:       return FACT2;
      default: return FACT3;
    endcase
  endfunction

  logic [PTX_NUM_FACT-1:0][MAX_W-1:0] fwd_all;
  logic [PTX_NUM_FACT-1:0][MAX_W-1:0] rev_all;
  logic [PTX_NUM_FACT-1:0][MAX_W-1:0] mask_all;

  for (genvar g = 0; g < PTX_NUM_FACT; g++) begin : g_fact
    localparam int unsigned N = fact_of(g);
    for (genvar b = 0; b < MAX_W; b++) begin : g_bit
      if (b < N) begin : g_on
        assign fwd_all[g][b]  = word_i[b];
        assign rev_all[g][b]  = word_i[N-1-b];
        assign mask_all[g][b] = 1'b1;
      end else begin : g_off
        assign fwd_all[g][b]  = 1'b0;
        assign rev_all[g][b]  = 1'b0;
        assign mask_all[g][b] = 1'b0;
      end
    end
  end

  logic [MAX_W-1:0] ordered;

  always_comb begin
    ordered = msb_first_i ? rev_all[sel_i] : fwd_all[sel_i];
    image_o = ordered ^ ({MAX_W{invert_i}} & mask_all[sel_i]);
  end

  always_comb begin
    case (sel_i)
      PTX_LEN_A: last_idx_o = CNT_W'(FACT0 - 1);
      PTX_LEN_B: last_idx_o = CNT_W'(FACT1 - 1);
      PTX_LEN_C: last_idx_o = CNT_W'(FACT2 - 1);
      default:   last_idx_o = CNT_W'(FACT3 - 1);
    endcase
  end

endmodule

// File: rtl/ptx_ctrl.sv
// Bit counter, busy/underflow state and load handshake.
module ptx_ctrl #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] last_idx_i,
  output logic             ready_o,
  output logic             take_o,
  output logic             shift_o,
  output logic             underflow_o
);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             under_q;
  logic             at_last;

  assign at_last     = busy_q && (cnt_q == '0);
  assign ready_o     = !busy_q || at_last;
  assign take_o      = load_i && ready_o;
  assign shift_o     = busy_q && !at_last;
  assign underflow_o = under_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      under_q <= 1'b0;
    end else if (take_o) begin
      busy_q  <= 1'b1;
      cnt_q   <= last_idx_i;
      under_q <= 1'b0;
    end else if (shift_o) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (at_last) begin
      busy_q  <= 1'b0;
      under_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ptx_shifter.sv
// Shift register with a registered serial output.
module ptx_shifter #(
  parameter int unsigned MAX_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_i,
  input  logic             shift_i,
  input  logic [MAX_W-1:0] image_i,
  output logic             ser_o
);

  logic [MAX_W-1:0] sreg_q;
  logic             ser_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      ser_q  <= 1'b0;
    end else if (take_i) begin
      ser_q  <= image_i[0];
      sreg_q <= image_i >> 1;
    end else if (shift_i) begin
      ser_q  <= sreg_q[0];
      sreg_q <= sreg_q >> 1;
    end else begin
      ser_q <= 1'b0;
    end
  end

  assign ser_o = ser_q;

endmodule

// File: rtl/par2ser_tx.sv
module par2ser_tx
  import ptx_pkg::*;
#(
  parameter int unsigned FACT0 = 8,
  parameter int unsigned FACT1 = 10,
  parameter int unsigned FACT2 = 16,
  parameter int unsigned FACT3 = 20,
  localparam int unsigned MAX_W = FACT3,
  localparam int unsigned CNT_W = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAX_W-1:0] word_i,
  input  logic [1:0]       width_sel_i,
  input  logic             invert_i,
  input  logic             msb_first_i,
  input  logic             load_i,
  output logic             ready_o,
  output logic             ser_o,
  output logic             underflow_o
);

  logic [MAX_W-1:0] image;
  logic [CNT_W-1:0] last_idx;
  logic             take;
  logic             shift;

  ptx_word_prep #(
    .FACT0(FACT0), .FACT1(FACT1), .FACT2(FACT2), .FACT3(FACT3)
  ) u_prep (
    .word_i      (word_i),
    .sel_i       (ptx_len_e'(width_sel_i)),
    .invert_i    (invert_i),
    .msb_first_i (msb_first_i),
    .image_o     (image),
    .last_idx_o  (last_idx)
  );

  ptx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .last_idx_i  (last_idx),
    .ready_o     (ready_o),
    .take_o      (take),
    .shift_o     (shift),
    .underflow_o (underflow_o)
  );

  ptx_shifter #(.MAX_W(MAX_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .take_i  (take),
    .shift_i (shift),
    .image_i (image),
    .ser_o   (ser_o)
  );

endmodule

// File: rtl/ptx_chk.sv
module ptx_chk #(
  parameter int unsigned FACT0 = 8,
  parameter int unsigned FACT1 = 10,
  parameter int unsigned FACT2 = 16,
  parameter int unsigned FACT3 = 20,
  localparam int unsigned CNT_W = $clog2(FACT3)
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] width_sel_i,
  input logic       load_i,
  input logic       ready_o,
  input logic       ser_o,
  input logic       underflow_o
);

  logic             seen_q;
  logic             act_q;
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_d;
  logic             accept;
  logic             at_end;

  assign accept = load_i && ready_o;
  assign at_end = act_q && (pos_q == lim_q);

  always_comb begin
    case (width_sel_i)
      2'd0:    lim_d = CNT_W'(FACT0 - 1);
      2'd1:    lim_d = CNT_W'(FACT1 - 1);
      2'd2:    lim_d = CNT_W'(FACT2 - 1);
      default: lim_d = CNT_W'(FACT3 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      act_q  <= 1'b0;
      pos_q  <= '0;
      lim_q  <= '0;
    end else if (accept) begin
      seen_q <= 1'b1;
      act_q  <= 1'b1;
      pos_q  <= '0;
      lim_q  <= lim_d;
    end else if (act_q) begin
      if (pos_q == lim_q) act_q <= 1'b0;
      else                pos_q <= pos_q + 1'b1;
    end
  end

  // R1 R7
  word_len_chk: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (ready_o == (pos_q == lim_q) && !underflow_o));

  // R9
  underflow_set_chk: assert property (@(posedge clk) disable iff (rst)
    (at_end && !load_i) |=> (underflow_o && !ser_o));

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    underflow_o |-> (ready_o && !ser_o));

  // R9
  underflow_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (underflow_o && load_i) |=> !underflow_o);

  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> (!ser_o && !underflow_o && ready_o));

endmodule

bind par2ser_tx ptx_chk #(
  .FACT0(FACT0), .FACT1(FACT1), .FACT2(FACT2), .FACT3(FACT3)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .width_sel_i (width_sel_i),
  .load_i      (load_i),
  .ready_o     (ready_o),
  .ser_o       (ser_o),
  .underflow_o (underflow_o)
);

// File: tb/test_par2ser_tx.sv
module test_par2ser_tx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] word_i = '0;
  logic [1:0]  width_sel_i = '0;
  logic        invert_i = 1'b0;
  logic        msb_first_i = 1'b0;
  logic        load_i = 1'b0;
  logic        ready_o;
  logic        ser_o;
  logic        underflow_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  par2ser_tx i_par2ser_tx (
    .clk         (clk),
    .rst         (rst),
    .word_i      (word_i),
    .width_sel_i (width_sel_i),
    .invert_i    (invert_i),
    .msb_first_i (msb_first_i),
    .load_i      (load_i),
    .ready_o     (ready_o),
    .ser_o       (ser_o),
    .underflow_o (underflow_o)
  );

  function automatic int nbits(input logic [1:0] s);
    case (s)
      2'd0:    return 8;
      2'd1:    return 10;
      2'd2:    return 16;
      default: return 20;
    endcase
  endfunction

  function automatic logic [19:0] expect_stream(input logic [19:0] w,
      input logic [1:0] s, input logic inv, input logic msb);
    logic [19:0] e = '0;
    int n = nbits(s);
    for (int i = 0; i < n; i++)
      e[i] = (msb ? w[n-1-i] : w[i]) ^ inv;
    return e;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Caller must be at a negedge with ready_o high. Leaves at the negedge of
  // the word's last bit with load_i low.
  task automatic run_word(input logic [19:0] w, input logic [1:0] s,
      input logic inv, input logic msb, input bit disturb, input string req);
    logic [19:0] cap = '0;
    logic [19:0] exp;
    bit rdy_ok = 1'b1;
    int n = nbits(s);
    check(ready_o === 1'b1, {req, " ready before load"}, ready_o, 1);
    word_i = w; width_sel_i = s; invert_i = inv; msb_first_i = msb;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    if (disturb) begin
      word_i = ~w; width_sel_i = ~s; invert_i = ~inv; msb_first_i = ~msb;
    end
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      cap[i] = ser_o;
      if (ready_o !== (i == n - 1) || underflow_o !== 1'b0) rdy_ok = 1'b0;
    end
    exp = expect_stream(w, s, inv, msb);
    check(cap === exp, req, cap, exp);
    check(rdy_ok, "R7 ready only on last bit", rdy_ok, 1);
  endtask

  task automatic t_reset;
    bit ok = 1'b1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (5) begin
      @(negedge clk);
      if (ser_o !== 1'b0 || underflow_o !== 1'b0 || ready_o !== 1'b1) ok = 1'b0;
    end
    check(ok, "R8 quiet after reset", {ser_o, underflow_o, ready_o}, 3'b001);
  endtask

  task automatic idle_check(input string req);
    bit ok = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (ser_o !== 1'b0 || underflow_o !== 1'b1 || ready_o !== 1'b1) ok = 1'b0;
    end
    check(ok, req, {ser_o, underflow_o, ready_o}, 3'b011);
  endtask

  task automatic t_lsb_factors;
    run_word(20'h000A5, 2'd0, 1'b0, 1'b0, 1'b0, "R1 R2 len8 lsb");
    idle_check("R9 underflow after len8");
    run_word(20'h0036C, 2'd1, 1'b0, 1'b0, 1'b0, "R1 R2 len10 lsb");
    idle_check("R9 underflow after len10");
    run_word(20'h0C3E1, 2'd2, 1'b0, 1'b0, 1'b0, "R1 R2 len16 lsb");
    idle_check("R9 underflow after len16");
    run_word(20'hB4E27, 2'd3, 1'b0, 1'b0, 1'b0, "R1 R2 len20 lsb");
    idle_check("R9 underflow after len20");
  endtask

  task automatic t_msb;
    run_word(20'h00013, 2'd0, 1'b0, 1'b1, 1'b0, "R3 len8 msb");
    run_word(20'h00281, 2'd1, 1'b0, 1'b1, 1'b0, "R3 len10 msb");
    run_word(20'h8001F, 2'd3, 1'b0, 1'b1, 1'b0, "R3 len20 msb");
    idle_check("R9 underflow after msb run");
  endtask

  task automatic t_invert;
    run_word(20'h0F0F0, 2'd2, 1'b1, 1'b0, 1'b0, "R4 len16 inverted");
    run_word(20'h00155, 2'd1, 1'b1, 1'b1, 1'b0, "R4 R3 len10 inverted msb");
    idle_check("R9 underflow after invert run");
  endtask

  task automatic t_disturb;
    run_word(20'h0005C, 2'd0, 1'b0, 1'b0, 1'b1, "R5 len8 controls changed mid-word");
    run_word(20'h5A3C9, 2'd3, 1'b1, 1'b1, 1'b1, "R5 len20 controls changed mid-word");
    idle_check("R9 underflow after disturb run");
  endtask

  task automatic t_upper;
    run_word(20'hFFF00, 2'd0, 1'b0, 1'b0, 1'b0, "R6 len8 upper bits ignored");
    run_word(20'hFFC00, 2'd1, 1'b0, 1'b1, 1'b0, "R6 len10 msb upper bits ignored");
    run_word(20'hF0000, 2'd2, 1'b1, 1'b0, 1'b0, "R6 len16 inverted upper ignored");
    idle_check("R9 underflow after upper run");
  endtask

  task automatic t_back_to_back;
    run_word(20'h000C7, 2'd0, 1'b0, 1'b0, 1'b0, "R7 chain word 1");
    run_word(20'hABCDE, 2'd3, 1'b1, 1'b0, 1'b0, "R7 chain word 2");
    run_word(20'h00391, 2'd1, 1'b0, 1'b1, 1'b0, "R7 chain word 3");
    run_word(20'h0E00F, 2'd2, 1'b0, 1'b0, 1'b0, "R7 chain word 4");
    idle_check("R9 underflow after chain");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_lsb_factors();
    t_msb();
    t_invert();
    t_disturb();
    t_upper();
    t_back_to_back();
    t_reset();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule